// File: doc/BRIEF.md
# Accumulator Processor Core with Indexed Addressing

This block is a small multicycle processor built around a 24-bit accumulator. Memory is byte addressed and 15 bits wide. Each instruction is one 24-bit word. The top byte is the opcode, bit 15 selects indexing, and the low 15 bits hold an address. The core also holds an index register, a link register for subroutine return, a program counter and a two-bit condition code. Every memory access goes through a single-port byte RAM outside the core. The RAM is synchronous: the byte for an address presented on one edge is on `mem_rdata` after the next edge. A 24-bit word therefore takes three byte cycles, most significant byte first.

Software runs the core with straight-line code, compare-and-branch loops and subroutines. A fused increment-and-compare on the index register closes counted loops in one instruction. Peripherals sit behind a polled byte port. Software first tests a device until it reports ready, then moves one byte with a single-cycle read or write strobe. Any opcode outside the supported set stops the core with a visible flag until the next reset.

Top module: `word_acc_core`

## Requirements
- R1: Instructions are fetched as three bytes from PC, PC, PC+1 and PC+2, with the first byte as bits [23:16]. The opcode is bits [23:16], the index flag is bit 15 and the address field is bits [14:0]. PC advances by 3 after each fetch.
- R2: The effective address is the address field when bit 15 is 0. When bit 15 is 1 it is the address field plus the low 15 bits of the index register, taken modulo 2^15.
- R3: Word loads and stores move 24 bits with the most significant byte at the lowest address. The opcodes are: load A 0x00, load index 0x04, load link 0x08, store A 0x0C, store index 0x10, store link 0x14.
- R4: Byte load (0x50) replaces only bits [7:0] of A and leaves bits [23:8] unchanged. Byte store (0x54) writes A[7:0] to the single byte at the effective address.
- R5: Add (0x18) and subtract (0x1C) update A with the two's complement result modulo 2^24.
- R6: Compare (0x28) compares A with the memory word as signed numbers. It sets the condition code to 00 for less, 01 for equal and 10 for greater. The code never takes the value 11.
- R7: Increment-and-compare (0x2C) adds 1 to the index register, then compares the new index with the memory word as signed numbers and sets the condition code as in R6.
- R8: Jump (0x3C) always loads PC with the effective address. Jump-if-equal (0x30), jump-if-greater (0x34) and jump-if-less (0x38) load PC only when the condition code matches. Otherwise execution falls through to the next instruction.
- R9: Call (0x48) writes the address of the following instruction, zero-extended, into the link register and jumps to the effective address. Return (0x4C) loads PC from the low 15 bits of the link register.
- R10: Device test (0xE0) reads the device number byte at the effective address and presents it on `dev_sel`. It sets the condition code to 00 (less) when `dev_ready` is 1 and to 01 (equal) when `dev_ready` is 0.
- R11: Device read (0xD8) pulses `dev_rd` for one cycle and loads `dev_rdata` into A[7:0], keeping A[23:8]. Device write (0xDC) pulses `dev_wr` for one cycle with `dev_wdata` equal to A[7:0]. `dev_rd` and `dev_wr` are never high together.
- R12: Any other opcode raises `illegal` and halts. `illegal` then stays high until reset, and no further memory write or device strobe occurs.
- R13: After reset, PC is 0, the accumulator, index and link registers are 0, `illegal` is low, no write is driven, and the first fetch addresses byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 15 | Byte address to the RAM |
| mem_we | output | 1 | Byte write enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Registered read byte, valid one cycle after its address |
| dev_sel | output | 8 | Device number for the I/O port |
| dev_rd | output | 1 | One-cycle device read strobe |
| dev_wr | output | 1 | One-cycle device write strobe |
| dev_wdata | output | 8 | Byte written to the device |
| dev_rdata | input | 8 | Byte returned by the device |
| dev_ready | input | 1 | Device ready status sampled by device test |
| illegal | output | 1 | Set by an unsupported opcode; the core is halted |

## Verification
The bench builds the core with its default parameters: a 15-bit address and a reset vector of 0. Programs, data and results therefore all fit in the bench's 4 KB RAM model near address 0. With the address width kept at 15, one indexed store has an address field plus index sum that passes 2^15. This exercises the modulo wrap of the effective address and lands the byte back in low memory. It also makes the signed-versus-unsigned compare cases and the 24-bit add overflow reachable with a few words of data.

// File: rtl/wac_pkg.sv
package wac_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int OPC_W  = 8;
    localparam int BYTE_W = 8;

    localparam logic [OPC_W-1:0] OPC_LDA  = 8'h00;
    localparam logic [OPC_W-1:0] OPC_LDX  = 8'h04;
    localparam logic [OPC_W-1:0] OPC_LDL  = 8'h08;
    localparam logic [OPC_W-1:0] OPC_STA  = 8'h0C;
    localparam logic [OPC_W-1:0] OPC_STX  = 8'h10;
    localparam logic [OPC_W-1:0] OPC_STL  = 8'h14;
    localparam logic [OPC_W-1:0] OPC_ADD  = 8'h18;
    localparam logic [OPC_W-1:0] OPC_SUB  = 8'h1C;
    localparam logic [OPC_W-1:0] OPC_CMP  = 8'h28;
    localparam logic [OPC_W-1:0] OPC_TIX  = 8'h2C;
    localparam logic [OPC_W-1:0] OPC_JEQ  = 8'h30;
    localparam logic [OPC_W-1:0] OPC_JGT  = 8'h34;
    localparam logic [OPC_W-1:0] OPC_JLT  = 8'h38;
    localparam logic [OPC_W-1:0] OPC_JMP  = 8'h3C;
    localparam logic [OPC_W-1:0] OPC_CALL = 8'h48;
    localparam logic [OPC_W-1:0] OPC_RET  = 8'h4C;
    localparam logic [OPC_W-1:0] OPC_LDB  = 8'h50;
    localparam logic [OPC_W-1:0] OPC_STB  = 8'h54;
    localparam logic [OPC_W-1:0] OPC_DRD  = 8'hD8;
    localparam logic [OPC_W-1:0] OPC_DWR  = 8'hDC;
    localparam logic [OPC_W-1:0] OPC_DTST = 8'hE0;

    // condition code encoding
    localparam logic [1:0] CC_LT = 2'b00;
    localparam logic [1:0] CC_EQ = 2'b01;
    localparam logic [1:0] CC_GT = 2'b10;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_MEMRD, S_MEMWR, S_IO, S_HALT
    } state_e;

    typedef enum logic [3:0] {
        C_LOAD, C_STORE, C_ADD, C_SUB, C_COMP, C_TIX, C_JUMP,
        C_CALL, C_RET, C_DTST, C_DRD, C_DWR, C_ILL
    } op_class_e;

    typedef enum logic [1:0] { R_A, R_X, R_L } reg_sel_e;

    typedef enum logic [1:0] { J_ALW, J_EQ, J_GT, J_LT } jcond_e;

    typedef struct packed {
        op_class_e cls;
        reg_sel_e  rsel;
        logic      byte_op;
        jcond_e    jc;
    } dec_t;

    function automatic logic cond_met(jcond_e jc, logic [1:0] cc);
        logic hit;
        case (jc)
            J_EQ:    hit = (cc == CC_EQ);
            J_GT:    hit = (cc == CC_GT);
            J_LT:    hit = (cc == CC_LT);
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction
endpackage

// File: rtl/wac_decode.sv
module wac_decode
    import wac_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output dec_t             dec_o
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        dec_o = '{cls: C_ILL, rsel: R_A, byte_op: 1'b0, jc: J_ALW};
        case (opc_i)
            OPC_LDA:  dec_o.cls = C_LOAD;
            OPC_LDX:  begin dec_o.cls = C_LOAD;  dec_o.rsel = R_X; end
            OPC_LDL:  begin dec_o.cls = C_LOAD;  dec_o.rsel = R_L; end
            OPC_STA:  dec_o.cls = C_STORE;
            OPC_STX:  begin dec_o.cls = C_STORE; dec_o.rsel = R_X; end
            OPC_STL:  begin dec_o.cls = C_STORE; dec_o.rsel = R_L; end
            OPC_LDB:  begin dec_o.cls = C_LOAD;  dec_o.byte_op = 1'b1; end
            OPC_STB:  begin dec_o.cls = C_STORE; dec_o.byte_op = 1'b1; end
            OPC_ADD:  dec_o.cls = C_ADD;
            OPC_SUB:  dec_o.cls = C_SUB;
            OPC_CMP:  dec_o.cls = C_COMP;
            OPC_TIX:  dec_o.cls = C_TIX;
            OPC_JMP:  dec_o.cls = C_JUMP;
            OPC_JEQ:  begin dec_o.cls = C_JUMP; dec_o.jc = J_EQ; end
            OPC_JGT:  begin dec_o.cls = C_JUMP; dec_o.jc = J_GT; end
            OPC_JLT:  begin dec_o.cls = C_JUMP; dec_o.jc = J_LT; end
            OPC_CALL: dec_o.cls = C_CALL;
            OPC_RET:  dec_o.cls = C_RET;
            OPC_DTST: begin dec_o.cls = C_DTST; dec_o.byte_op = 1'b1; end
            OPC_DRD:  begin dec_o.cls = C_DRD;  dec_o.byte_op = 1'b1; end
            OPC_DWR:  begin dec_o.cls = C_DWR;  dec_o.byte_op = 1'b1; end
            default:  dec_o.cls = C_ILL;
        endcase
    end
endmodule

// File: rtl/wac_alu.sv
module wac_alu
    import wac_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic [1:0]   cc_o
);
    timeunit 1ns;
    timeprecision 100ps;

    always_comb begin
        res_o = sub_i ? (lhs_i - rhs_i) : (lhs_i + rhs_i);
        if ($signed(lhs_i) < $signed(rhs_i))
            cc_o = CC_LT;
        else if (lhs_i == rhs_i)
            cc_o = CC_EQ;
        else
            cc_o = CC_GT;
    end
endmodule

// File: rtl/word_acc_core.sv
module word_acc_core
    import wac_pkg::*;
#(
    parameter int          ADDR_W   = 15,
    parameter int unsigned RESET_PC = 0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] dev_sel,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [BYTE_W-1:0] dev_wdata,
    input  logic [BYTE_W-1:0] dev_rdata,
    input  logic              dev_ready,
    output logic              illegal
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int WORD_W = OPC_W + 1 + ADDR_W;
    localparam int WB     = WORD_W / BYTE_W;
    localparam int CNT_W  = $clog2(WB + 1);
    localparam int LO_W   = WORD_W - BYTE_W;

    state_e              state_q;
    logic [CNT_W-1:0]    bcnt_q, nbytes;
    logic [LO_W-1:0]     shreg_q;
    logic [WORD_W-1:0]   ir_q, a_q, x_q, l_q;
    logic [WORD_W-1:0]   assembled, st_src, alu_res, x_inc, alu_lhs;
    logic [ADDR_W-1:0]   pc_q, ta_q, ta_calc, base;
    logic [1:0]          cc_q, alu_cc;
    logic [BYTE_W-1:0]   dev_q, wr_byte;
    logic                rd_done, wr_last, is_word, tix_exec;
    dec_t                dec;

    // instruction fields
    wac_decode u_dec (
        .opc_i (ir_q[WORD_W-1 -: OPC_W]),
        .dec_o (dec)
    );

    assign ta_calc = ir_q[ADDR_W-1:0] + (ir_q[ADDR_W] ? x_q[ADDR_W-1:0] : '0);

    // byte sequencing shared by fetch, operand read and store
    assign is_word   = (state_q == S_FETCH) || !dec.byte_op;
    assign nbytes    = is_word ? CNT_W'(WB) : CNT_W'(1);
    assign rd_done   = (bcnt_q == nbytes);
    assign wr_last   = (bcnt_q == nbytes - 1'b1);
    assign base      = (state_q == S_FETCH) ? pc_q : ta_q;
    assign mem_addr  = base + ADDR_W'(bcnt_q);
    assign mem_we    = (state_q == S_MEMWR);
    assign assembled = {shreg_q, mem_rdata};

    always_comb begin
        case (dec.rsel)
            R_X:     st_src = x_q;
            R_L:     st_src = l_q;
            default: st_src = a_q;
        endcase
    end

    // big-endian byte selection for stores
    always_comb begin
        wr_byte = st_src[BYTE_W-1:0];
        if (!dec.byte_op) begin
            for (int k = 0; k < WB; k++) begin
                if (bcnt_q == CNT_W'(k))
                    wr_byte = st_src[BYTE_W*(WB-1-k) +: BYTE_W];
            end
        end
    end
    assign mem_wdata = wr_byte;

    assign x_inc   = x_q + 1'b1;
    assign alu_lhs = (dec.cls == C_TIX) ? x_inc : a_q;

    wac_alu #(.W(WORD_W)) u_alu (
        .lhs_i (alu_lhs),
        .rhs_i (assembled),
        .sub_i (dec.cls == C_SUB),
        .res_o (alu_res),
        .cc_o  (alu_cc)
    );

    assign dev_sel   = dev_q;
    assign dev_rd    = (state_q == S_IO) && (dec.cls == C_DRD);
    assign dev_wr    = (state_q == S_IO) && (dec.cls == C_DWR);
    assign dev_wdata = a_q[BYTE_W-1:0];
    assign illegal   = (state_q == S_HALT);
    assign tix_exec  = (state_q == S_MEMRD) && rd_done && (dec.cls == C_TIX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_FETCH;
            bcnt_q  <= '0;
            shreg_q <= '0;
            ir_q    <= '0;
            pc_q    <= ADDR_W'(RESET_PC);
            ta_q    <= '0;
            a_q     <= '0;
            x_q     <= '0;
            l_q     <= '0;
            cc_q    <= CC_LT;
            dev_q   <= '0;
        end else begin
            case (state_q)
                S_FETCH: begin
                    if (bcnt_q != '0)
                        shreg_q <= LO_W'({shreg_q, mem_rdata});
                    if (rd_done) begin
                        ir_q    <= assembled;
                        pc_q    <= pc_q + ADDR_W'(WB);
                        bcnt_q  <= '0;
                        state_q <= S_DECODE;
                    end else begin
                        bcnt_q  <= bcnt_q + 1'b1;
                    end
                end
                S_DECODE: begin
                    ta_q   <= ta_calc;
                    bcnt_q <= '0;
                    case (dec.cls)
                        C_ILL:   state_q <= S_HALT;
                        C_JUMP: begin
                            if (cond_met(dec.jc, cc_q))
                                pc_q <= ta_calc;
                            state_q <= S_FETCH;
                        end
                        C_CALL: begin
                            l_q     <= WORD_W'(pc_q);
                            pc_q    <= ta_calc;
                            state_q <= S_FETCH;
                        end
                        C_RET: begin
                            pc_q    <= l_q[ADDR_W-1:0];
                            state_q <= S_FETCH;
                        end
                        C_STORE: state_q <= S_MEMWR;
                        default: state_q <= S_MEMRD;
                    endcase
                end
                S_MEMRD: begin
                    if (bcnt_q != '0)
                        shreg_q <= LO_W'({shreg_q, mem_rdata});
                    if (rd_done) begin
                        bcnt_q  <= '0;
                        state_q <= S_FETCH;
                        case (dec.cls)
                            C_LOAD: begin
                                if (dec.byte_op)
                                    a_q[BYTE_W-1:0] <= mem_rdata;
                                else begin
                                    case (dec.rsel)
                                        R_X:     x_q <= assembled;
                                        R_L:     l_q <= assembled;
                                        default: a_q <= assembled;
                                    endcase
                                end
                            end
                            C_ADD, C_SUB: a_q <= alu_res;
                            C_COMP: cc_q <= alu_cc;
                            C_TIX: begin
                                x_q  <= x_inc;
                                cc_q <= alu_cc;
                            end
                            C_DTST, C_DRD, C_DWR: begin
                                dev_q   <= mem_rdata;
                                state_q <= S_IO;
                            end
                            default: ;
                        endcase
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                S_MEMWR: begin
                    if (wr_last) begin
                        bcnt_q  <= '0;
                        state_q <= S_FETCH;
                    end else begin
                        bcnt_q  <= bcnt_q + 1'b1;
                    end
                end
                S_IO: begin
                    if (dec.cls == C_DTST)
                        cc_q <= dev_ready ? CC_LT : CC_EQ;
                    else if (dec.cls == C_DRD)
                        a_q[BYTE_W-1:0] <= dev_rdata;
                    state_q <= S_FETCH;
                end
                S_HALT:  state_q <= S_HALT;
                default: state_q <= S_HALT;
            endcase
        end
    end

    // R1: consecutive fetch bytes come from consecutive addresses
    a_r1_fetch_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_FETCH && bcnt_q != '0) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R5: a subtract result added back to the operand yields the accumulator input
    a_r5_sub_undo: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_MEMRD && rd_done && dec.cls == C_SUB) |-> WORD_W'(alu_res + assembled) == a_q);

    // R6: the condition code never holds the unused value
    a_r6_cc_code: assert property (@(posedge clk) disable iff (rst) cc_q != 2'b11);

    // R7: increment-and-compare raises the index by exactly one
    a_r7_tix_step: assert property (@(posedge clk) disable iff (rst)
        tix_exec |=> x_q == WORD_W'($past(x_q) + 1'b1));

    // R11: device strobes are exclusive
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst) !(dev_rd && dev_wr));

    // R12: halt is sticky and silent
    a_r12_halt_sticky: assert property (@(posedge clk) disable iff (rst) illegal |=> illegal);
    a_r12_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_we && !dev_rd && !dev_wr));
endmodule

// File: tb/word_acc_core_tb.sv
module word_acc_core_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MEM_BYTES = 4096;
    localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, LDL = 8'h08, STA = 8'h0C,
        STX = 8'h10, STL = 8'h14, ADD = 8'h18, SUB = 8'h1C, CMP = 8'h28,
        TIX = 8'h2C, JEQ = 8'h30, JGT = 8'h34, JLT = 8'h38, JMP = 8'h3C,
        CALL = 8'h48, RET = 8'h4C, LDB = 8'h50, STB = 8'h54, DRD = 8'hD8,
        DWR = 8'hDC, DTST = 8'hE0, HALT = 8'hFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  dev_sel, dev_wdata;
    logic        dev_rd, dev_wr;
    logic [7:0]  dev_rdata = 8'h5A;
    logic        dev_ready = 1'b1;
    logic        illegal;

    always #2.5 clk = ~clk;

    word_acc_core dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_sel(dev_sel),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ready(dev_ready), .illegal(illegal)
    );

    logic [7:0] ram [MEM_BYTES];

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[11:0]];
    end

    int n_chk = 0, n_fail = 0;
    int run_cyc = 0, ready_at = 0;
    int rd_cnt = 0, wr_cnt = 0, stray = 0, halt_act = 0, first_rd = 0;
    logic [7:0] rd_sel = 0, wr_sel = 0, wr_data = 0;

    // device model and activity monitor, away from the rising edge
    always @(negedge clk) begin
        if (rst) begin
            run_cyc = 0; rd_cnt = 0; wr_cnt = 0; halt_act = 0; first_rd = 0;
        end else begin
            run_cyc++;
            if (dev_rd) begin
                if (rd_cnt == 0) first_rd = run_cyc;
                rd_cnt++;
                rd_sel = dev_sel;
            end
            if (dev_wr) begin
                wr_cnt++;
                wr_sel = dev_sel;
                wr_data = dev_wdata;
            end
            if (mem_we && mem_addr >= 15'(MEM_BYTES)) stray++;
            if (illegal && (mem_we || dev_rd || dev_wr)) halt_act++;
        end
        dev_ready = (run_cyc >= ready_at);
    end

    task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_w(int a, logic [23:0] w);
        ram[a] = w[23:16]; ram[a+1] = w[15:8]; ram[a+2] = w[7:0];
    endtask

    task automatic put_i(int a, logic [7:0] op, logic x, logic [14:0] f);
        put_w(a, {op, x, f});
    endtask

    function automatic logic [23:0] get_w(int a);
        return {ram[a], ram[a+1], ram[a+2]};
    endfunction

    task automatic begin_test();
        @(negedge clk);
        rst = 1'b1;
        ready_at = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < MEM_BYTES; i++) ram[i] = 8'h00;
    endtask

    task automatic go(string tag);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 4000 && !illegal; c++) @(negedge clk);
        chk(tag, 24'(illegal), 24'd1);
    endtask

    task automatic t_reset();
        begin_test();
        for (int i = 0; i < 9; i++) ram[16'h200 + i] = 8'hEE;
        put_i(0, STA, 0, 15'h200);
        put_i(3, STX, 0, 15'h203);
        put_i(6, STL, 0, 15'h206);
        put_i(9, HALT, 0, 0);
        chk("R13 reset illegal low", 24'(illegal), 0);
        chk("R13 reset no write", 24'(mem_we), 0);
        chk("R13 reset no strobe", 24'(dev_rd | dev_wr), 0);
        chk("R13 reset fetch address", 24'(mem_addr), 0);
        go("R13 program ends");
        chk("R13 A after reset", get_w(16'h200), 0);
        chk("R13 X after reset", get_w(16'h203), 0);
        chk("R13 L after reset", get_w(16'h206), 0);
    endtask

    task automatic t_load_store_arith();
        begin_test();
        put_i(0,  LDA, 0, 15'h100);
        put_i(3,  ADD, 0, 15'h103);
        put_i(6,  SUB, 0, 15'h106);
        put_i(9,  STA, 0, 15'h200);
        put_i(12, LDX, 0, 15'h109);
        put_i(15, STX, 0, 15'h203);
        put_i(18, LDL, 0, 15'h10C);
        put_i(21, STL, 0, 15'h206);
        put_i(24, LDA, 0, 15'h10F);
        put_i(27, ADD, 0, 15'h112);
        put_i(30, STA, 0, 15'h209);
        put_i(33, HALT, 0, 0);
        put_w(16'h100, 24'h123456); put_w(16'h103, 24'h00F00F);
        put_w(16'h106, 24'h000001); put_w(16'h109, 24'hA1B2C3);
        put_w(16'h10C, 24'h0F0E0D); put_w(16'h10F, 24'hFFFFFF);
        put_w(16'h112, 24'h000002);
        go("R1 straight-line program runs");
        chk("R5 add then subtract", get_w(16'h200), 24'(24'h123456 + 24'h00F00F - 24'h1));
        chk("R3 big-endian top byte first", 24'(ram[16'h200]), 24'(8'h13));
        chk("R3 index load/store", get_w(16'h203), 24'hA1B2C3);
        chk("R3 link load/store", get_w(16'h206), 24'h0F0E0D);
        chk("R5 add wraps modulo 2^24", get_w(16'h209), 24'h000001);
    endtask

    task automatic t_index_byte();
        begin_test();
        for (int i = 0; i < 8; i++) ram[16'h300 + i] = 8'hEE;
        ram[16'h210] = 8'hEE; ram[16'h211] = 8'hEE;
        put_i(0,  LDX, 0, 15'h100);
        put_i(3,  LDA, 0, 15'h103);
        put_i(6,  LDB, 1, 15'h110);
        put_i(9,  STA, 0, 15'h200);
        put_i(12, STB, 1, 15'h300);
        put_i(15, LDX, 0, 15'h106);
        put_i(18, STB, 1, 15'h7F00);
        put_i(21, HALT, 0, 0);
        put_w(16'h100, 24'h000005); put_w(16'h103, 24'hABCDEF);
        put_w(16'h106, 24'h000310);
        ram[16'h115] = 8'h5A;
        go("R2 indexed program runs");
        chk("R4 byte load keeps upper A", get_w(16'h200), 24'hABCD5A);
        chk("R2 indexed byte store", 24'(ram[16'h305]), 24'h5A);
        chk("R4 byte store leaves neighbours", {8'h0, ram[16'h304], ram[16'h306]}, 24'h00EEEE);
        chk("R2 address wraps modulo 2^15", {ram[16'h210], ram[16'h211]}, 24'h5AEE);
    endtask

    task automatic t_compare(logic [23:0] a, logic [23:0] b);
        logic [23:0] exp;
        begin_test();
        put_i(0,  LDA, 0, 15'h100);
        put_i(3,  CMP, 0, 15'h103);
        put_i(6,  JLT, 0, 15'h30);
        put_i(9,  JEQ, 0, 15'h40);
        put_i(12, JGT, 0, 15'h50);
        put_i(15, HALT, 0, 0);
        for (int k = 0; k < 3; k++) begin
            put_i(16'h30 + 16*k, LDA, 0, 15'(16'h109 + 3*k));
            put_i(16'h33 + 16*k, STA, 0, 15'h200);
            put_i(16'h36 + 16*k, HALT, 0, 0);
        end
        put_w(16'h100, a); put_w(16'h103, b);
        put_w(16'h109, 1); put_w(16'h10C, 2); put_w(16'h10F, 3);
        exp = ($signed(a) < $signed(b)) ? 24'd1 : (a == b) ? 24'd2 : 24'd3;
        go("R6 compare program runs");
        chk("R6/R8 signed compare selects branch", get_w(16'h200), exp);
    endtask

    task automatic t_jump();
        begin_test();
        put_i(0, JMP, 0, 15'h60);
        put_i(3, HALT, 0, 0);
        put_i(16'h60, LDA, 0, 15'h100);
        put_i(16'h63, STA, 0, 15'h200);
        put_i(16'h66, HALT, 0, 0);
        put_w(16'h100, 24'h000777);
        go("R8 jump program runs");
        chk("R8 unconditional jump taken", get_w(16'h200), 24'h000777);
    endtask

    task automatic t_tix_loop();
        logic [7:0] src [6];
        src = '{8'h53, 8'h54, 8'h52, 8'h49, 8'h4E, 8'h47};
        begin_test();
        put_i(0,  LDX, 0, 15'h100);
        put_i(3,  LDB, 1, 15'h120);
        put_i(6,  STB, 1, 15'h200);
        put_i(9,  TIX, 0, 15'h103);
        put_i(12, JLT, 0, 15'h3);
        put_i(15, STX, 0, 15'h180);
        put_i(18, HALT, 0, 0);
        put_w(16'h100, 0); put_w(16'h103, 6);
        for (int i = 0; i < 6; i++) ram[16'h120 + i] = src[i];
        ram[16'h126] = 8'h77; ram[16'h206] = 8'hEE;
        go("R7 counted loop runs");
        for (int i = 0; i < 6; i++) chk("R7 loop copies byte", 24'(ram[16'h200 + i]), 24'(src[i]));
        chk("R7 loop stops at bound", 24'(ram[16'h206]), 24'hEE);
        chk("R7 final index", get_w(16'h180), 24'd6);
    endtask

    task automatic t_subroutine();
        begin_test();
        put_i(0, CALL, 0, 15'h40);
        put_i(3, STL, 0, 15'h200);
        put_i(6, HALT, 0, 0);
        put_i(16'h40, LDA, 0, 15'h100);
        put_i(16'h43, STA, 0, 15'h206);
        put_i(16'h46, RET, 0, 0);
        put_w(16'h100, 24'h000011);
        go("R9 call/return program runs");
        chk("R9 link holds return address", get_w(16'h200), 24'd3);
        chk("R9 subroutine body ran", get_w(16'h206), 24'h000011);
    endtask

    task automatic t_io();
        begin_test();
        ready_at = 60;
        put_i(0,  LDA, 0, 15'h104);
        put_i(3,  DTST, 0, 15'h100);
        put_i(6,  JEQ, 0, 15'h3);
        put_i(9,  DRD, 0, 15'h100);
        put_i(12, STA, 0, 15'h200);
        put_i(15, DTST, 0, 15'h101);
        put_i(18, JEQ, 0, 15'hF);
        put_i(21, DWR, 0, 15'h101);
        put_i(24, HALT, 0, 0);
        ram[16'h100] = 8'h21; ram[16'h101] = 8'h05;
        put_w(16'h104, 24'hABCD00);
        go("R10 polled I/O program runs");
        chk("R10 read waits for ready", 24'(first_rd >= ready_at), 24'd1);
        chk("R11 one read strobe", 24'(rd_cnt), 24'd1);
        chk("R10 read device number", 24'(rd_sel), 24'h21);
        chk("R11 read keeps upper A", get_w(16'h200), 24'hABCD5A);
        chk("R11 one write strobe", 24'(wr_cnt), 24'd1);
        chk("R10 write device number", 24'(wr_sel), 24'h05);
        chk("R11 write data is A low byte", 24'(wr_data), 24'h5A);
    endtask

    task automatic t_illegal();
        begin_test();
        put_i(0, LDA, 0, 15'h100);
        put_i(3, 8'h03, 0, 0);
        put_i(6, STA, 0, 15'h200);
        put_i(9, HALT, 0, 0);
        put_w(16'h100, 24'h123123);
        put_w(16'h200, 24'hEEEEEE);
        go("R12 illegal opcode halts");
        repeat (20) @(negedge clk);
        chk("R12 flag stays set", 24'(illegal), 24'd1);
        chk("R12 no store after halt", get_w(16'h200), 24'hEEEEEE);
        chk("R12 no activity while halted", 24'(halt_act), 0);
    endtask

    initial begin
        t_reset();
        t_load_store_arith();
        t_index_byte();
        t_compare(24'd5, 24'd7);
        t_compare(24'd7, 24'd7);
        t_compare(24'hFFFFFF, 24'd1);
        t_compare(24'h7FFFFF, 24'h800000);
        t_jump();
        t_tix_loop();
        t_subroutine();
        t_io();
        t_illegal();
        chk("R2 no write beyond modelled RAM", 24'(stray), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R1..R13 run) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule